// File: doc/BRIEF.md
# TDM Audio Receive Deserializer

This block is the receive side of a time-division-multiplexed audio port. It samples a serial data line once per bit clock, using strobes that mark the rising and falling edges of the bit clock in the system clock domain. A frame sync marks where each frame begins. From that bit stream it rebuilds one word per slot and hands each word, tagged with its slot number, to a downstream FIFO over a valid/ready stream.

The configuration inputs choose the sampling edge, the sync style (a short pulse that starts the frame on its own bit or on the next one, or a long level), the slot width, the word width inside the slot, whether the word sits at the start or the end of the slot, and the number of slots per frame. A receive enable gates all capture. The configuration inputs are expected to be held steady while a frame is in flight.

Back-pressure rules: `out_valid` stays high, with `out_data` and `out_slot` stable, until a cycle with `out_ready` high. A transfer takes place in every cycle where both are high. The serial side cannot be stalled. A word that completes while the output still holds an unaccepted word is discarded, and the sticky `overrun` flag is set. It stays set until reset.

Top module: `tdm_rx_deser`

## Requirements
- R1: With `cfg_pol`=0 the data and sync lines are sampled only in cycles where `bck_fall` is high. With `cfg_pol`=1 they are sampled only in cycles where `bck_rise` is high.
- R2: A frame starts where the sampled sync goes from 0 to 1. With `cfg_long_sync`=0 and `cfg_early`=0, that same bit is bit 0 of slot 0. With `cfg_long_sync`=0 and `cfg_early`=1, bit 0 of slot 0 is the next sampled bit.
- R3: With `cfg_long_sync`=1 only the 0-to-1 transition of sync is used, and slot 0 starts on that bit. `cfg_early` has no effect in this mode.
- R4: `cfg_slot_len` gives the slot width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits.
- R5: `cfg_word_len` gives the word width: 0 gives 8, 1 gives 16, 2 gives 20, 3 gives 24, and 4 to 7 give 32 bits. When the word is wider than the slot, the slot width is used.
- R6: With `cfg_left_just`=1 the word is taken from the first bits of the slot. With `cfg_left_just`=0 it is taken from the last bits of the slot.
- R7: Bits arrive most significant first. `out_data` holds the word right-aligned, with all bits above the word width at zero.
- R8: `cfg_slots` (4 bits; the supported values are 1, 2, 4, 6 and 8) sets how many slots are captured after each frame start. `out_slot` carries the slot number, counting from 0. Later slots produce no words until the next frame start.
- R9: A word becomes valid in the clock cycle after its last bit is sampled. While `out_ready` is low, `out_valid`, `out_data` and `out_slot` hold their values.
- R10: When a word completes while `out_valid`=1 and `out_ready`=0, that word is dropped and `overrun` goes to 1. `overrun` stays at 1 until reset.
- R11: While `rx_en`=0 no bit is captured and no word is produced, and any frame in progress is abandoned. The configuration inputs keep their effect once `rx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_rise | input | 1 | One-cycle strobe marking a rising bit-clock edge |
| bck_fall | input | 1 | One-cycle strobe marking a falling bit-clock edge |
| sync_in | input | 1 | Frame sync line |
| sdata_in | input | 1 | Serial receive data |
| cfg_long_sync | input | 1 | 1 = long (level) sync, 0 = short pulse sync |
| cfg_early | input | 1 | Short sync only: 1 = slot 0 starts one bit after the sync bit |
| cfg_pol | input | 1 | Sampling edge: 0 = falling, 1 = rising |
| cfg_slot_len | input | 2 | Slot width code |
| cfg_word_len | input | 3 | Word width code |
| cfg_slots | input | SLOT_W | Slots per frame |
| cfg_left_just | input | 1 | 1 = word at the start of the slot, 0 = word at the end |
| rx_en | input | 1 | Receive enable |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can accept the word |
| out_data | output | DATA_W | Recovered word, right-aligned and zero-extended |
| out_slot | output | SLOT_W | Slot number of the word |
| overrun | output | 1 | Sticky flag: a word was dropped |

## Verification
The hardest situation to reach is the overrun path. The serial side has no stall, so a word can only collide with an unaccepted one if the stream is held off for a whole slot. The bench therefore holds `out_ready` low across a two-slot frame, then checks that the first word is still presented, that the second word was dropped, and that the flag stays set after the first word is drained. The framing corners are a second focus: an early sync bit ahead of slot 0, a long sync with the early bit set, and an extra slot after the configured count. They are reached by sweeping every combination of polarity, sync style, slot width, word width and justification against arithmetically predicted words.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;

  // Slot width in bits for a slot length code.
  function automatic logic [5:0] slot_bits(input logic [1:0] code);
    case (code)
      2'd0:    slot_bits = 6'd8;
      2'd1:    slot_bits = 6'd16;
      default: slot_bits = 6'd32;
    endcase
  endfunction

  // Word width in bits for a word length code.
  function automatic logic [5:0] word_bits(input logic [2:0] code);
    case (code)
      3'd0:    word_bits = 6'd8;
      3'd1:    word_bits = 6'd16;
      3'd2:    word_bits = 6'd20;
      3'd3:    word_bits = 6'd24;
      default: word_bits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/tdmrx_tick.sv
// Picks the sampling strobe and finds the frame-sync rising edge.
module tdmrx_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_rise,
  input  logic bck_fall,
  input  logic pol,
  input  logic sync_in,
  output logic tick,
  output logic sync_rise
);
  logic prev_sync_q;

  assign tick      = pol ? bck_rise : bck_fall;
  assign sync_rise = tick & sync_in & ~prev_sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    prev_sync_q <= 1'b0;
    else if (tick) prev_sync_q <= sync_in;
  end
endmodule

// File: rtl/tdmrx_framer.sv
// Tracks the position of each sampled bit inside the frame.
module tdmrx_framer #(
  parameter int unsigned POS_W  = 5,
  parameter int unsigned SLOT_W = 4,
  localparam int unsigned LEN_W = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              sync_rise,
  input  logic              early_eff,
  input  logic [LEN_W-1:0]  slot_len,
  input  logic [SLOT_W-1:0] slots,
  output logic              bit_valid,
  output logic [POS_W-1:0]  bit_pos,
  output logic [SLOT_W-1:0] bit_slot,
  output logic              bit_last
);
  logic              act_q, pend_q;
  logic [POS_W-1:0]  pos_q;
  logic [SLOT_W-1:0] slot_q;
  logic              raw_valid;
  logic [SLOT_W:0]   slot_inc;

  always_comb begin
    raw_valid = 1'b0;
    bit_pos   = pos_q;
    bit_slot  = slot_q;
    if (tick && en) begin
      if (sync_rise && !early_eff) begin
        raw_valid = 1'b1;
        bit_pos   = '0;
        bit_slot  = '0;
      end else if (sync_rise) begin
        raw_valid = 1'b0;
      end else if (pend_q) begin
        raw_valid = 1'b1;
        bit_pos   = '0;
        bit_slot  = '0;
      end else if (act_q) begin
        raw_valid = 1'b1;
      end
    end
    bit_valid = raw_valid && (bit_slot < slots);
    bit_last  = ({1'b0, bit_pos} == (slot_len - LEN_W'(1)));
  end

  assign slot_inc = {1'b0, bit_slot} + (SLOT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      pos_q  <= '0;
      slot_q <= '0;
    end else if (!en) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (tick) begin
      if (sync_rise && early_eff) begin
        pend_q <= 1'b1;
        act_q  <= 1'b0;
      end else if (bit_valid) begin
        pend_q <= 1'b0;
        if (bit_last) begin
          pos_q  <= '0;
          slot_q <= slot_inc[SLOT_W-1:0];
          act_q  <= (slot_inc < {1'b0, slots});
        end else begin
          pos_q  <= bit_pos + POS_W'(1);
          slot_q <= bit_slot;
          act_q  <= 1'b1;
        end
      end else begin
        pend_q <= 1'b0;
        act_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdmrx_shifter.sv
// Collects the bits inside the word window of a slot, MSB first.
module tdmrx_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POS_W  = 5,
  localparam int unsigned LEN_W = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              bit_last,
  input  logic              sdata,
  input  logic [LEN_W-1:0]  slot_len,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              left_just,
  output logic              emit,
  output logic [DATA_W-1:0] emit_word
);
  logic [DATA_W-1:0] acc_q, acc_base;
  logic [LEN_W-1:0]  eff_len;
  logic              in_window;

  always_comb begin
    eff_len   = (word_len < slot_len) ? word_len : slot_len;
    in_window = left_just ? ({1'b0, bit_pos} < eff_len)
                          : ({1'b0, bit_pos} >= (slot_len - eff_len));
    acc_base  = (bit_pos == '0) ? '0 : acc_q;
    emit_word = in_window ? {acc_base[DATA_W-2:0], sdata} : acc_base;
    emit      = bit_valid & bit_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         acc_q <= '0;
    else if (bit_valid) acc_q <= emit_word;
  end
endmodule

// File: rtl/tdmrx_outq.sv
// One-entry valid/ready output holding register with a sticky overrun flag.
module tdmrx_outq #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [DATA_W-1:0] emit_word,
  input  logic [SLOT_W-1:0] emit_slot,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [SLOT_W-1:0] out_slot,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_slot  <= '0;
      overrun   <= 1'b0;
    end else if (emit) begin
      if (out_valid && !out_ready) begin
        overrun <= 1'b1;
      end else begin
        out_valid <= 1'b1;
        out_data  <= emit_word;
        out_slot  <= emit_slot;
      end
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck_rise,
  input  logic              bck_fall,
  input  logic              sync_in,
  input  logic              sdata_in,
  input  logic              cfg_long_sync,
  input  logic              cfg_early,
  input  logic              cfg_pol,
  input  logic [1:0]        cfg_slot_len,
  input  logic [2:0]        cfg_word_len,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              cfg_left_just,
  input  logic              rx_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [SLOT_W-1:0] out_slot,
  output logic              overrun
);
  import tdmrx_pkg::*;

  localparam int unsigned POS_W = $clog2(DATA_W);
  localparam int unsigned LEN_W = POS_W + 1;

  logic              tick, sync_rise, early_eff;
  logic [LEN_W-1:0]  slot_len, word_len;
  logic              bit_valid, bit_last, emit;
  logic [POS_W-1:0]  bit_pos;
  logic [SLOT_W-1:0] bit_slot;
  logic [DATA_W-1:0] emit_word;

  assign early_eff = cfg_early & ~cfg_long_sync;
  assign slot_len  = LEN_W'(slot_bits(cfg_slot_len));
  assign word_len  = LEN_W'(word_bits(cfg_word_len));

  tdmrx_tick u_tick (
    .clk(clk), .rst_n(rst_n), .bck_rise(bck_rise), .bck_fall(bck_fall),
    .pol(cfg_pol), .sync_in(sync_in), .tick(tick), .sync_rise(sync_rise)
  );

  tdmrx_framer #(.POS_W(POS_W), .SLOT_W(SLOT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .sync_rise(sync_rise),
    .early_eff(early_eff), .slot_len(slot_len), .slots(cfg_slots),
    .bit_valid(bit_valid), .bit_pos(bit_pos), .bit_slot(bit_slot),
    .bit_last(bit_last)
  );

  tdmrx_shifter #(.DATA_W(DATA_W), .POS_W(POS_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_pos(bit_pos),
    .bit_last(bit_last), .sdata(sdata_in), .slot_len(slot_len),
    .word_len(word_len), .left_just(cfg_left_just), .emit(emit),
    .emit_word(emit_word)
  );

  tdmrx_outq #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_outq (
    .clk(clk), .rst_n(rst_n), .emit(emit), .emit_word(emit_word),
    .emit_slot(bit_slot), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_slot(out_slot), .overrun(overrun)
  );
endmodule

// File: rtl/tdm_rx_deser_chk.sv
module tdm_rx_deser_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bck_rise,
  input logic              bck_fall,
  input logic              cfg_pol,
  input logic [2:0]        cfg_word_len,
  input logic [SLOT_W-1:0] cfg_slots,
  input logic              rx_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [SLOT_W-1:0] out_slot,
  input logic              overrun
);
  import tdmrx_pkg::*;

  AST_EDGE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(cfg_pol ? bck_rise : bck_fall)); // R1

  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ((out_data >> word_bits(cfg_word_len)) == '0)); // R7

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_slot < cfg_slots)); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_slot))); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R10

  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(out_valid)); // R11
endmodule

bind tdm_rx_deser tdm_rx_deser_chk #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bck_rise(bck_rise), .bck_fall(bck_fall),
  .cfg_pol(cfg_pol), .cfg_word_len(cfg_word_len), .cfg_slots(cfg_slots),
  .rx_en(rx_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_slot(out_slot), .overrun(overrun)
);

// File: tb/sim_tdm_rx_deser.sv
module sim_tdm_rx_deser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck_rise = 0, bck_fall = 0, sync_in = 0, sdata_in = 0;
  logic cfg_long_sync = 0, cfg_early = 0, cfg_pol = 0, cfg_left_just = 1;
  logic [1:0] cfg_slot_len = 0;
  logic [2:0] cfg_word_len = 0;
  logic [3:0] cfg_slots = 4'd2;
  logic rx_en = 0, out_ready = 1;
  logic out_valid, overrun;
  logic [31:0] out_data;
  logic [3:0] out_slot;

  int total = 0, bad = 0, ngot = 0;
  bit done = 0;
  logic [31:0] got_data [64];
  logic [3:0]  got_slot [64];

  always #5 clk = ~clk;

  tdm_rx_deser u0 (
    .clk(clk), .rst_n(rst_n), .bck_rise(bck_rise), .bck_fall(bck_fall),
    .sync_in(sync_in), .sdata_in(sdata_in), .cfg_long_sync(cfg_long_sync),
    .cfg_early(cfg_early), .cfg_pol(cfg_pol), .cfg_slot_len(cfg_slot_len),
    .cfg_word_len(cfg_word_len), .cfg_slots(cfg_slots),
    .cfg_left_just(cfg_left_just), .rx_en(rx_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_slot(out_slot),
    .overrun(overrun)
  );

  always @(negedge clk) begin
    if (out_valid && out_ready && ngot < 64) begin
      got_data[ngot] = out_data;
      got_slot[ngot] = out_slot;
      ngot = ngot + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sl_of(input int code);
    return (code == 0) ? 8 : (code == 1) ? 16 : 32;
  endfunction
  function automatic int wl_of(input int code);
    return (code == 0) ? 8 : (code == 1) ? 16 : (code == 2) ? 20 : (code == 3) ? 24 : 32;
  endfunction
  function automatic longint slot_val(input int seed, input int s, input int sl);
    longint v;
    v = longint'((32'h9E3779B1 * (seed + 1)) ^ (32'h85EBCA6B * (s + 3)));
    return v & ((64'd1 << sl) - 1);
  endfunction
  function automatic longint exp_word(input longint v, input int sl, input int wl, input bit lj);
    int e;
    e = (wl < sl) ? wl : sl;
    return lj ? (v >> (sl - e)) : (v & ((64'd1 << e) - 1));
  endfunction

  // One bit: the selected strobe carries the real bit, the other strobe carries its inverse.
  task automatic drive_bit(input logic d, input logic s);
    @(negedge clk);
    sync_in = s; sdata_in = d;
    bck_rise = cfg_pol; bck_fall = ~cfg_pol;
    @(negedge clk);
    sdata_in = ~d;
    bck_rise = ~cfg_pol; bck_fall = cfg_pol;
    @(negedge clk);
    bck_rise = 0; bck_fall = 0;
  endtask

  // mode 0 short/late, 1 short/early, 2 long, 3 long with early bit set
  task automatic drive_frame(input int mode, input int sl, input int slots, input int seed);
    drive_bit(0, 0); drive_bit(1, 0);
    if (mode == 1) drive_bit(1, 1);
    for (int s = 0; s <= slots; s++) begin
      longint v;
      v = slot_val(seed, s, sl);
      for (int b = 0; b < sl; b++) begin
        logic sy;
        if (mode >= 2) sy = (s == 0);
        else           sy = (mode == 0) && (s == 0) && (b == 0);
        drive_bit(v[sl-1-b], sy);
      end
    end
    drive_bit(0, 0); drive_bit(0, 0);
  endtask

  task automatic run_frame(input int pol, input int mode, input int slc, input int wlc,
                           input bit lj, input int slots, input int seed, input bit expect_words);
    int sl, wl, nexp;
    cfg_pol = pol[0]; cfg_long_sync = (mode >= 2); cfg_early = (mode == 1 || mode == 3);
    cfg_slot_len = slc[1:0]; cfg_word_len = wlc[2:0]; cfg_left_just = lj;
    cfg_slots = slots[3:0];
    sl = sl_of(slc); wl = wl_of(wlc);
    ngot = 0;
    drive_frame(mode, sl, slots, seed);
    nexp = expect_words ? slots : 0;
    chk(ngot == nexp, expect_words ? "R8 word count" : "R11 words while disabled", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++) begin
      longint e;
      e = exp_word(slot_val(seed, i, sl), sl, wl, lj);
      chk(got_data[i] == e[31:0], "R1 R2 R3 R4 R5 R6 R7 word", got_data[i], e);
      chk(got_slot[i] == i[3:0], "R8 slot index", got_slot[i], i);
    end
  endtask

  initial begin
    int idx;
    int tbl [5] = '{1, 2, 4, 6, 8};
    repeat (4) @(negedge clk);
    chk(out_valid == 0, "reset out_valid", out_valid, 0);
    chk(overrun == 0, "reset overrun", overrun, 0);
    chk(out_data == 0, "reset out_data", out_data, 0);
    rst_n = 1; rx_en = 1;
    idx = 0;
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 3; s++)
          for (int w = 0; w < 5; w++)
            for (int j = 0; j < 2; j++) begin
              run_frame(p, m, s, w, j[0], tbl[idx % 5], idx, 1);
              idx++;
            end
    chk(overrun == 0, "R10 no overrun with ready high", overrun, 0);

    // R11: disabled receive, then re-enabled with configuration kept
    rx_en = 0;
    run_frame(1, 0, 1, 1, 1, 4, 901, 0);
    rx_en = 1;
    ngot = 0;
    drive_frame(0, 16, 4, 902);
    chk(ngot == 4, "R11 count after re-enable", ngot, 4);
    chk(got_data[1] == exp_word(slot_val(902, 1, 16), 16, 16, 1), "R11 word after re-enable",
        got_data[1], exp_word(slot_val(902, 1, 16), 16, 16, 1));

    // R9/R10: stall the stream across a two-slot frame
    out_ready = 0;
    cfg_pol = 1; cfg_long_sync = 0; cfg_early = 0; cfg_slot_len = 1; cfg_word_len = 1;
    cfg_left_just = 1; cfg_slots = 2;
    ngot = 0;
    drive_frame(0, 16, 2, 77);
    chk(out_valid == 1, "R9 held valid", out_valid, 1);
    chk(out_data == slot_val(77, 0, 16), "R9 R10 first word kept", out_data, slot_val(77, 0, 16));
    chk(out_slot == 0, "R10 kept slot", out_slot, 0);
    chk(overrun == 1, "R10 overrun set", overrun, 1);
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    @(negedge clk);
    chk(ngot == 1, "R10 one word delivered", ngot, 1);
    chk(out_valid == 0, "R9 drained", out_valid, 0);
    chk(overrun == 1, "R10 overrun sticky", overrun, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule